// File: doc/BRIEF.md
# Packed SAD Block Accumulator

This block measures how closely two pixel blocks match by computing their sum of absolute differences. Each block is 16 pixels wide and either 8 or 16 rows tall. A start pulse carries the row count. After that, the block takes one row pair per handshake. A row pair is one 128-bit word from each block, each word holding sixteen unsigned 8-bit pixels.

The block keeps a packed accumulator with one lane per pixel column. For each accepted row pair, every lane adds the absolute difference of its two pixels. The lanes are summed only once, after the last row. A registered four-level adder tree reduces the sixteen lanes to one scalar, and a one-cycle done pulse presents that scalar. The block does not generate addresses or access memory; an upstream unit feeds it rows in order.

Top module: `sad_block_acc`

## Requirements
- R1: While reset is held and after it is released, `done_o` and `row_ready_o` are low and `sad_o` is zero.
- R2: A start pulse with `height_i` = 8, taken while the block is idle, makes the block accept exactly 8 rows. `row_ready_o` then goes low.
- R3: A start pulse with `height_i` = 16, taken while the block is idle, makes the block accept exactly 16 rows. `row_ready_o` then goes low.
- R4: A start pulse with any `height_i` other than 8 or 16 is ignored. `row_ready_o` stays low and no done pulse follows.
- R5: The result is the sum over all accepted rows and all columns of |a - b|. The pixel of column i sits in bits [8i+7:8i] of `blk_a_i` and `blk_b_i`, and both pixels are read as unsigned.
- R6: The accumulator lanes clear on each accepted start, so a result never includes rows from an earlier block.
- R7: `done_o` is a one-cycle pulse. It rises on the fifth rising edge after the edge that accepts the last row.
- R8: A row is taken only on an edge where `row_valid_i` and `row_ready_o` are both high. Data presented while valid is low, or while the block is idle, has no effect.
- R9: The extreme inputs (255 against 0, either order, 16 rows) give 65280 without overflow in any lane or in the result.
- R10: `sad_o` keeps its value between done pulses. A start pulse that arrives while a block is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only while idle |
| height_i | input | 5 | Row count for the block, valid with start_i (8 or 16) |
| row_valid_i | input | 1 | A row pair is present on the data inputs |
| row_ready_o | output | 1 | The block can take a row pair this cycle |
| blk_a_i | input | 128 | Sixteen 8-bit pixels of a row of the first block |
| blk_b_i | input | 128 | Sixteen 8-bit pixels of the matching row of the second block |
| done_o | output | 1 | One-cycle pulse when sad_o is updated |
| sad_o | output | 16 | Scalar sum of absolute differences |

## Verification
The bench builds the block with its default parameters: 16 lanes of 12 bits, a 16-bit result and a tree of depth 4. With these values, both legal heights can be tested, and full-range pixels drive every lane to its 4080 maximum and the result to 65280. The tests use varied pixel patterns, gaps in valid that carry garbage data, a start pulse sent in the middle of a block, a start with an illegal height, and blocks sent back to back. A scoreboard compares each done pulse against the expected sum and against the expected five-edge latency.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCUM  = 2'd1,
    ST_REDUCE = 2'd2
  } sad_state_e;
endpackage

// File: rtl/sad_lane_acc.sv
// Packed accumulator: one lane per pixel column, each adding |a-b| per row.
module sad_lane_acc #(
  parameter int LANES  = 16,
  parameter int PIX_W  = 8,
  parameter int LANE_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic [LANES*PIX_W-1:0]  a_i,
  input  logic [LANES*PIX_W-1:0]  b_i,
  output logic [LANES*LANE_W-1:0] acc_o
);
  genvar g;
  for (g = 0; g < LANES; g++) begin : g_lane
    logic [PIX_W-1:0]  pa, pb, diff;
    logic [LANE_W-1:0] acc_q, acc_d;

    assign pa   = a_i[g*PIX_W +: PIX_W];
    assign pb   = b_i[g*PIX_W +: PIX_W];
    assign diff = (pa >= pb) ? (pa - pb) : (pb - pa);

    always_comb begin
      acc_d = acc_q;
      if (clr_i)     acc_d = '0;
      else if (en_i) acc_d = acc_q + LANE_W'(diff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             acc_q <= '0;
      else if (clr_i || en_i) acc_q <= acc_d;
    end

    assign acc_o[g*LANE_W +: LANE_W] = acc_q;
  end
endmodule

// File: rtl/sad_reduce_tree.sv
// Registered binary adder tree; one level per clock while enabled.
module sad_reduce_tree #(
  parameter int LANES  = 16,
  parameter int LANE_W = 12,
  parameter int RES_W  = 16,
  localparam int DEPTH = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic [LANES*LANE_W-1:0] acc_i,
  output logic [RES_W-1:0]        sum_o
);
  genvar l, j;
  for (l = 0; l < DEPTH; l++) begin : g_lvl
    localparam int N = LANES >> (l + 1);
    logic [RES_W-1:0] sum_q [N];
    for (j = 0; j < N; j++) begin : g_node
      logic [RES_W-1:0] sum_d;
      if (l == 0) begin : g_leaf
        assign sum_d = RES_W'(acc_i[(2*j)*LANE_W +: LANE_W])
                     + RES_W'(acc_i[(2*j+1)*LANE_W +: LANE_W]);
      end else begin : g_inner
        assign sum_d = g_lvl[l-1].sum_q[2*j] + g_lvl[l-1].sum_q[2*j+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sum_q[j] <= '0;
        else if (en_i) sum_q[j] <= sum_d;
      end
    end
  end
  assign sum_o = g_lvl[DEPTH-1].sum_q[0];
endmodule

// File: rtl/sad_ctrl.sv
// Sequencer: start decode, row counting, reduction timing, done pulse.
module sad_ctrl #(
  parameter int H_SMALL = 8,
  parameter int H_LARGE = 16,
  parameter int DEPTH   = 4,
  localparam int HGT_W  = $clog2(H_LARGE) + 1,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [HGT_W-1:0] height_i,
  input  logic             row_valid_i,
  output logic             row_ready_o,
  output logic             acc_clr_o,
  output logic             acc_en_o,
  output logic             tree_en_o,
  output logic             done_o,
  output logic             load_res_o
);
  import sad_pkg::*;

  sad_state_e       state_q, state_d;
  logic [HGT_W-1:0] rows_q, rows_d;
  logic [CNT_W-1:0] red_q, red_d;
  logic             done_q, done_d;
  logic             h_ok, take_start, take_row;

  assign h_ok       = (height_i == HGT_W'(H_SMALL)) || (height_i == HGT_W'(H_LARGE));
  assign take_start = (state_q == ST_IDLE) && start_i && h_ok;
  assign take_row   = (state_q == ST_ACCUM) && row_valid_i;

  always_comb begin
    state_d    = state_q;
    rows_d     = rows_q;
    red_d      = red_q;
    done_d     = 1'b0;
    load_res_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (take_start) begin
          rows_d  = height_i;
          state_d = ST_ACCUM;
        end
      end
      ST_ACCUM: begin
        if (take_row) begin
          rows_d = rows_q - HGT_W'(1);
          if (rows_q == HGT_W'(1)) begin
            red_d   = '0;
            state_d = ST_REDUCE;
          end
        end
      end
      ST_REDUCE: begin
        if (red_q == CNT_W'(DEPTH)) begin
          done_d     = 1'b1;
          load_res_o = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          red_d = red_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rows_q  <= '0;
      red_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rows_q  <= rows_d;
      red_q   <= red_d;
      done_q  <= done_d;
    end
  end

  assign row_ready_o = (state_q == ST_ACCUM);
  assign acc_clr_o   = take_start;
  assign acc_en_o    = take_row;
  assign tree_en_o   = (state_q == ST_REDUCE);
  assign done_o      = done_q;
endmodule

// File: rtl/sad_block_acc.sv
module sad_block_acc #(
  parameter int LANES   = 16,
  parameter int PIX_W   = 8,
  parameter int LANE_W  = 12,
  parameter int RES_W   = 16,
  parameter int H_SMALL = 8,
  parameter int H_LARGE = 16,
  localparam int HGT_W  = $clog2(H_LARGE) + 1,
  localparam int DEPTH  = $clog2(LANES),
  localparam int ROW_W  = LANES * PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [HGT_W-1:0] height_i,
  input  logic             row_valid_i,
  output logic             row_ready_o,
  input  logic [ROW_W-1:0] blk_a_i,
  input  logic [ROW_W-1:0] blk_b_i,
  output logic             done_o,
  output logic [RES_W-1:0] sad_o
);
  logic                    acc_clr, acc_en, tree_en, load_res;
  logic [LANES*LANE_W-1:0] acc;
  logic [RES_W-1:0]        tree_sum;
  logic [RES_W-1:0]        sad_q;

  sad_ctrl #(.H_SMALL(H_SMALL), .H_LARGE(H_LARGE), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .height_i(height_i),
    .row_valid_i(row_valid_i), .row_ready_o(row_ready_o),
    .acc_clr_o(acc_clr), .acc_en_o(acc_en), .tree_en_o(tree_en),
    .done_o(done_o), .load_res_o(load_res)
  );

  sad_lane_acc #(.LANES(LANES), .PIX_W(PIX_W), .LANE_W(LANE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .en_i(acc_en),
    .a_i(blk_a_i), .b_i(blk_b_i), .acc_o(acc)
  );

  sad_reduce_tree #(.LANES(LANES), .LANE_W(LANE_W), .RES_W(RES_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .en_i(tree_en), .acc_i(acc), .sum_o(tree_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sad_q <= '0;
    else if (load_res) sad_q <= tree_sum;
  end

  assign sad_o = sad_q;
endmodule

// File: rtl/sad_block_acc_chk.sv
module sad_block_acc_chk #(
  parameter int HGT_W   = 5,
  parameter int RES_W   = 16,
  parameter int H_SMALL = 8,
  parameter int H_LARGE = 16,
  parameter int MAX_SUM = 65280
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [HGT_W-1:0] height_i,
  input logic             row_valid_i,
  input logic             row_ready_o,
  input logic             done_o,
  input logic [RES_W-1:0] sad_o
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(row_valid_i && row_ready_o, 6));

  // R2
  done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !row_ready_o);

  // R4
  bad_height_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_ready_o && start_i && height_i != HGT_W'(H_SMALL)
     && height_i != HGT_W'(H_LARGE) && !done_o) |=> !row_ready_o);

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(sad_o));

  // R9
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sad_o) <= MAX_SUM);
endmodule

bind sad_block_acc sad_block_acc_chk #(.HGT_W(HGT_W), .RES_W(RES_W),
  .H_SMALL(H_SMALL), .H_LARGE(H_LARGE), .MAX_SUM(H_LARGE * LANES * 255)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .height_i(height_i),
  .row_valid_i(row_valid_i), .row_ready_o(row_ready_o),
  .done_o(done_o), .sad_o(sad_o)
);

// File: tb/sad_block_acc_test.sv
`timescale 1ns/1ps
module sad_block_acc_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [4:0]   height_i;
  logic         row_valid_i;
  logic         row_ready_o;
  logic [127:0] blk_a_i, blk_b_i;
  logic         done_o;
  logic [15:0]  sad_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_sad_q[$];
  int exp_cyc_q[$];
  logic prev_done = 1'b0;
  logic [15:0] last_sad = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sad_block_acc uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .height_i(height_i),
    .row_valid_i(row_valid_i), .row_ready_o(row_ready_o),
    .blk_a_i(blk_a_i), .blk_b_i(blk_b_i), .done_o(done_o), .sad_o(sad_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pix(input int mode, input int seed,
                                     input int r, input int i, input bit side_b);
    if (mode == 1) return side_b ? 8'd0 : 8'd255;
    if (mode == 2) return side_b ? 8'd255 : 8'd0;
    if (side_b) return 8'((seed * 53 + r * 17 + i * 71 + 9) % 256);
    return 8'((seed * 29 + r * 41 + i * 13) % 256);
  endfunction

  // Monitor: pop expected result and latency at each done (R5, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o && prev_done) check("R7 done wider than one cycle", 1, 0);
      if (done_o) begin
        if (exp_sad_q.size() == 0) begin
          check("R4 unexpected done", 1, 0);
        end else begin
          int e, c;
          e = exp_sad_q.pop_front();
          c = exp_cyc_q.pop_front();
          check("R5 sad value", int'(sad_o), e);
          check("R7 done latency", cyc - c, 5);
          last_sad = sad_o;
        end
      end
    end
    prev_done = done_o;
  end

  // Driver: start, feed h rows, push expected (R2 R3 R6 R8 R10)
  task automatic run_block(input int h, input int mode, input int seed,
                           input bit gaps, input bit mid_start);
    int sum = 0;
    @(negedge clk);
    start_i = 1'b1; height_i = 5'(h);
    @(negedge clk);
    start_i = 1'b0;
    for (int r = 0; r < h; r++) begin
      if (gaps && (r % 3 == 1)) begin
        row_valid_i = 1'b0;
        blk_a_i = {16{8'hFF}}; blk_b_i = '0;
        @(negedge clk);
      end
      row_valid_i = 1'b1;
      for (int i = 0; i < 16; i++) begin
        logic [7:0] a, b;
        a = pix(mode, seed, r, i, 1'b0);
        b = pix(mode, seed, r, i, 1'b1);
        blk_a_i[8*i +: 8] = a;
        blk_b_i[8*i +: 8] = b;
        sum += (a >= b) ? int'(a - b) : int'(b - a);
      end
      start_i = (mid_start && r == 2);
      height_i = 5'd8;
      while (!row_ready_o) @(negedge clk);
      if (r == h - 1) begin
        exp_sad_q.push_back(sum);
        exp_cyc_q.push_back(cyc + 1);
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    row_valid_i = 1'b0;
    // R2/R3: exactly h rows taken, ready drops after the last one
    check(h == 8 ? "R2 ready low after 8 rows" : "R3 ready low after 16 rows",
          int'(row_ready_o), 0);
    while (exp_sad_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; height_i = '0; row_valid_i = 1'b0;
    blk_a_i = '0; blk_b_i = '0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", int'(done_o), 0);
    check("R1 ready in reset", int'(row_ready_o), 0);
    check("R1 sad in reset", int'(sad_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ready after reset", int'(row_ready_o), 0);
    check("R1 sad after reset", int'(sad_o), 0);

    // R8: valid with data while idle has no effect
    row_valid_i = 1'b1; blk_a_i = {16{8'hAA}}; blk_b_i = '0;
    repeat (3) @(negedge clk);
    row_valid_i = 1'b0;
    check("R8 idle rows not taken", int'(row_ready_o), 0);

    run_block(8, 0, 1, 1'b0, 1'b0);   // R2 R5
    run_block(16, 0, 7, 1'b0, 1'b0);  // R3 R5 R6
    run_block(16, 0, 3, 1'b1, 1'b0);  // R8 gaps
    run_block(16, 0, 5, 1'b0, 1'b1);  // R10 start while busy ignored
    run_block(16, 1, 0, 1'b0, 1'b0);  // R9 255 vs 0
    run_block(16, 2, 0, 1'b0, 1'b0);  // R9 0 vs 255
    run_block(8, 0, 11, 1'b1, 1'b0);  // R6 small block after max

    // R4: illegal height ignored
    @(negedge clk);
    start_i = 1'b1; height_i = 5'd12;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) begin
      check("R4 ready stays low", int'(row_ready_o), 0);
      @(negedge clk);
    end
    // R10: result held between done pulses
    check("R10 sad held", int'(sad_o), int'(last_sad));
    run_block(8, 0, 2, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule